// File: doc/BRIEF.md
# Serial Flash Erase Controller

This block is the device-side control logic of a serial flash memory that deals with erasure. A host talks to it over an SPI-style link in mode 0 (chip select active low, serial clock idle low, data sampled on the rising clock edge, most significant bit first). The link, oversampled by the block's own clock, carries five instructions: set the write-enable latch, read the status byte, and erase a 4 KB sector, a 64 KB block (sixteen adjacent sectors) or the whole array. Erasure leaves every bit of the region at 1. The memory cells are abstract: the block presents the aligned region start, its kind and a busy flag on an erase-request port, and an array model performs the erase while busy is high.

An erase instruction takes effect only when chip select is released on a byte boundary after a complete instruction. It also needs a write-enable latch that an earlier, separate instruction has set. The block then counts a parameterised number of cycles for that erase kind, reports write-in-progress in the status byte, ignores every instruction except status read, and clears the latch when the count ends.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Opcode 0x06, sent as the first byte and closed by a chip-select rise on a byte boundary, sets the write-enable latch (status bit 1).
- R2: Opcode 0x05 shifts the status byte {6'b0, latch, in-progress} out on sdo, MSB first, updated on each falling serial clock edge, and repeats it while chip select stays low; sdo is 0 while deselected.
- R3: Opcode 0x20 with three address bytes (most significant first) launches a sector erase at the chip-select rise: erase_kind = 1 and erase_addr is the address with its low 12 bits cleared.
- R4: Opcode 0xD8 with three address bytes launches a block erase: erase_kind = 2 and erase_addr is the address with its low 16 bits cleared.
- R5: Opcode 0xC7 alone launches a whole-array erase: erase_kind = 3 and erase_addr = 0.
- R6: An erase instruction sent while the write-enable latch is clear does nothing.
- R7: A chip-select rise that is not on a byte boundary, or that comes before all three address bytes of a sector or block erase, leaves busy and the latch unchanged.
- R8: erase_busy stays high for exactly SECT_CYCLES, BLOCK_CYCLES or CHIP_CYCLES clock cycles by kind. erase_addr and erase_kind hold steady during that time, status bit 0 reads 1, and erase_kind is 0 when idle.
- R9: The write-enable latch clears in the cycle the erase completes.
- R10: While busy, every instruction other than status read is ignored: no second erase follows and the region outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock (mode 0) |
| sdi | input | 1 | Serial data toward the block |
| sdo | output | 1 | Serial data from the block (status byte) |
| erase_busy | output | 1 | Erase in progress toward the array |
| erase_kind | output | 2 | 0 idle, 1 sector, 2 block, 3 whole array |
| erase_addr | output | 24 | Aligned start byte address of the region |

## Verification
The checker watches on every cycle that a new busy period starts only in the cycle after a chip-select release, and only with the latch already set. It also checks that the region outputs are aligned to their kind and hold still while busy, that the latch is clear as soon as busy falls, and that sdo stays quiet while the link is deselected. Only the bench scenarios can show the instruction decoding itself: the exact status bits on the wire, the busy length per kind, the silent rejection of framing errors and missing latch, and the erase instruction that is dropped during a running erase.

// File: rtl/fe_pkg.sv
`timescale 1ns/1ps
package fe_pkg;
  localparam int ADDR_W   = 24;
  localparam int SECT_LG2 = 12;
  localparam int BLK_LG2  = 16;
  localparam int ADDR_BYTES = ADDR_W / 8;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_SECT  = 8'h20;
  localparam logic [7:0] OP_BLOCK = 8'hD8;
  localparam logic [7:0] OP_CHIP  = 8'hC7;

  typedef enum logic [1:0] {
    ER_NONE  = 2'd0,
    ER_SECT  = 2'd1,
    ER_BLOCK = 2'd2,
    ER_CHIP  = 2'd3
  } er_kind_t;
endpackage

// File: rtl/fe_spi_rx.sv
`timescale 1ns/1ps
module fe_spi_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       cs_idle,
  output logic       cs_rise,
  output logic       sclk_fall,
  output logic       byte_vld,
  output logic [7:0] byte_val,
  output logic [2:0] byte_idx,
  output logic       frame_aligned,
  output logic [2:0] frame_bytes
);
  localparam logic [2:0] BYTE_MAX = 3'(fe_pkg::ADDR_BYTES + 1);

  logic [2:0] sync_q [SYNC_STAGES];
  logic       s_cs_n, s_sclk, s_sdi;
  logic       cs_prev_q, sclk_prev_q;
  logic [2:0] bit_cnt_q, bit_cnt_d;
  logic [2:0] byte_cnt_q, byte_cnt_d;
  logic [6:0] shreg_q, shreg_d;
  logic       sclk_rise;

  // synchroniser chain: {cs_n, sclk, sdi}
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 3'b100;
    end else begin
      sync_q[0] <= {cs_n, sclk, sdi};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s_cs_n = sync_q[SYNC_STAGES-1][2];
  assign s_sclk = sync_q[SYNC_STAGES-1][1];
  assign s_sdi  = sync_q[SYNC_STAGES-1][0];

  always_comb begin
    sclk_rise     = s_sclk & ~sclk_prev_q & ~s_cs_n;
    sclk_fall     = ~s_sclk & sclk_prev_q & ~s_cs_n;
    cs_rise       = s_cs_n & ~cs_prev_q;
    cs_idle       = s_cs_n;
    byte_vld      = sclk_rise & (bit_cnt_q == 3'd7);
    byte_val      = {shreg_q, s_sdi};
    byte_idx      = byte_cnt_q;
    frame_aligned = (bit_cnt_q == 3'd0);
    frame_bytes   = byte_cnt_q;

    bit_cnt_d  = bit_cnt_q;
    byte_cnt_d = byte_cnt_q;
    shreg_d    = shreg_q;
    if (s_cs_n) begin
      bit_cnt_d  = 3'd0;
      byte_cnt_d = 3'd0;
    end else if (sclk_rise) begin
      bit_cnt_d = bit_cnt_q + 3'd1;
      shreg_d   = {shreg_q[5:0], s_sdi};
      if (byte_vld && byte_cnt_q != BYTE_MAX) byte_cnt_d = byte_cnt_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
      bit_cnt_q   <= 3'd0;
      byte_cnt_q  <= 3'd0;
      shreg_q     <= 7'd0;
    end else begin
      cs_prev_q   <= s_cs_n;
      sclk_prev_q <= s_sclk;
      bit_cnt_q   <= bit_cnt_d;
      byte_cnt_q  <= byte_cnt_d;
      shreg_q     <= shreg_d;
    end
  end
endmodule

// File: rtl/fe_cmd_dec.sv
`timescale 1ns/1ps
module fe_cmd_dec
  import fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              cs_rise,
  input  logic              sclk_fall,
  input  logic              byte_vld,
  input  logic [7:0]        byte_val,
  input  logic [2:0]        byte_idx,
  input  logic              frame_aligned,
  input  logic [2:0]        frame_bytes,
  input  logic              busy,
  input  logic              erase_done,
  output logic              wel,
  output logic              launch,
  output er_kind_t          launch_kind,
  output logic [ADDR_W-1:0] launch_addr,
  output logic              sdo
);
  localparam logic [2:0] FULL_BYTES = 3'(ADDR_BYTES + 1);

  logic [7:0]        op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rdsr_q, rdsr_d;
  logic              wel_q, wel_d;
  logic [2:0]        ocnt_q, ocnt_d;
  logic              sdo_q, sdo_d;
  logic [7:0]        status;
  logic              wel_set;
  logic              full_frame, any_frame;

  always_comb begin
    status     = {6'b0, wel_q, busy};
    full_frame = (frame_bytes >= FULL_BYTES);
    any_frame  = (frame_bytes != 3'd0);

    op_d   = op_q;
    addr_d = addr_q;
    rdsr_d = rdsr_q;
    ocnt_d = ocnt_q;
    sdo_d  = sdo_q;

    if (byte_vld) begin
      if (byte_idx == 3'd0) begin
        op_d   = byte_val;
        rdsr_d = (byte_val == OP_RDSR);
      end else if (byte_idx < FULL_BYTES) begin
        addr_d = {addr_q[ADDR_W-9:0], byte_val};
      end
    end

    if (cs_idle) begin
      rdsr_d = 1'b0;
      ocnt_d = 3'd0;
      sdo_d  = 1'b0;
    end else if (sclk_fall && rdsr_q) begin
      sdo_d  = status[3'd7 - ocnt_q];
      ocnt_d = ocnt_q + 3'd1;
    end

    wel_set     = 1'b0;
    launch      = 1'b0;
    launch_kind = ER_NONE;
    if (cs_rise && frame_aligned && !busy && any_frame) begin
      case (op_q)
        OP_WREN:  wel_set = 1'b1;
        OP_SECT:  if (full_frame && wel_q) begin launch = 1'b1; launch_kind = ER_SECT;  end
        OP_BLOCK: if (full_frame && wel_q) begin launch = 1'b1; launch_kind = ER_BLOCK; end
        OP_CHIP:  if (wel_q)               begin launch = 1'b1; launch_kind = ER_CHIP;  end
        default:  ;
      endcase
    end

    case (launch_kind)
      ER_SECT:  launch_addr = {addr_q[ADDR_W-1:SECT_LG2], {SECT_LG2{1'b0}}};
      ER_BLOCK: launch_addr = {addr_q[ADDR_W-1:BLK_LG2],  {BLK_LG2{1'b0}}};
      default:  launch_addr = '0;
    endcase

    if (erase_done)   wel_d = 1'b0;
    else if (wel_set) wel_d = 1'b1;
    else              wel_d = wel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= 8'h00;
      addr_q <= '0;
      rdsr_q <= 1'b0;
      wel_q  <= 1'b0;
      ocnt_q <= 3'd0;
      sdo_q  <= 1'b0;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_d;
      rdsr_q <= rdsr_d;
      wel_q  <= wel_d;
      ocnt_q <= ocnt_d;
      sdo_q  <= sdo_d;
    end
  end

  assign wel = wel_q;
  assign sdo = sdo_q;
endmodule

// File: rtl/fe_erase_timer.sv
`timescale 1ns/1ps
module fe_erase_timer
  import fe_pkg::*;
#(
  parameter int SECT_CYCLES  = 4000,
  parameter int BLOCK_CYCLES = 16000,
  parameter int CHIP_CYCLES  = 64000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  er_kind_t          launch_kind,
  input  logic [ADDR_W-1:0] launch_addr,
  output logic              busy,
  output logic              done,
  output er_kind_t          kind,
  output logic [ADDR_W-1:0] addr
);
  localparam int MAX_AB = (SECT_CYCLES > BLOCK_CYCLES) ? SECT_CYCLES : BLOCK_CYCLES;
  localparam int MAX_C  = (MAX_AB > CHIP_CYCLES) ? MAX_AB : CHIP_CYCLES;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] LOAD_S = CNT_W'(SECT_CYCLES - 1);
  localparam logic [CNT_W-1:0] LOAD_B = CNT_W'(BLOCK_CYCLES - 1);
  localparam logic [CNT_W-1:0] LOAD_C = CNT_W'(CHIP_CYCLES - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  er_kind_t          kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    kind_d = kind_q;
    addr_d = addr_q;
    done   = busy_q && (cnt_q == '0);
    if (launch) begin
      busy_d = 1'b1;
      kind_d = launch_kind;
      addr_d = launch_addr;
      case (launch_kind)
        ER_SECT:  cnt_d = LOAD_S;
        ER_BLOCK: cnt_d = LOAD_B;
        default:  cnt_d = LOAD_C;
      endcase
    end else if (done) begin
      busy_d = 1'b0;
      kind_d = ER_NONE;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      kind_q <= ER_NONE;
      addr_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
    end
  end

  assign busy = busy_q;
  assign kind = kind_q;
  assign addr = addr_q;
endmodule

// File: rtl/flash_erase_ctrl.sv
`timescale 1ns/1ps
module flash_erase_ctrl
  import fe_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int SECT_CYCLES  = 4000,
  parameter int BLOCK_CYCLES = 16000,
  parameter int CHIP_CYCLES  = 64000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              erase_busy,
  output logic [1:0]        erase_kind,
  output logic [ADDR_W-1:0] erase_addr
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              cs_idle, cs_rise, sclk_fall;
  logic              byte_vld;
  logic [7:0]        byte_val;
  logic [2:0]        byte_idx, frame_bytes;
  logic              frame_aligned;
  logic              wel, launch, erase_done;
  er_kind_t          launch_kind, kind;
  logic [ADDR_W-1:0] launch_addr;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  fe_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_core_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cs_idle(cs_idle), .cs_rise(cs_rise), .sclk_fall(sclk_fall),
    .byte_vld(byte_vld), .byte_val(byte_val), .byte_idx(byte_idx),
    .frame_aligned(frame_aligned), .frame_bytes(frame_bytes)
  );

  fe_cmd_dec u_dec (
    .clk(clk), .rst_n(rst_core_n), .cs_idle(cs_idle), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .byte_vld(byte_vld), .byte_val(byte_val),
    .byte_idx(byte_idx), .frame_aligned(frame_aligned), .frame_bytes(frame_bytes),
    .busy(erase_busy), .erase_done(erase_done), .wel(wel), .launch(launch),
    .launch_kind(launch_kind), .launch_addr(launch_addr), .sdo(sdo)
  );

  fe_erase_timer #(
    .SECT_CYCLES(SECT_CYCLES), .BLOCK_CYCLES(BLOCK_CYCLES), .CHIP_CYCLES(CHIP_CYCLES)
  ) u_tmr (
    .clk(clk), .rst_n(rst_core_n), .launch(launch), .launch_kind(launch_kind),
    .launch_addr(launch_addr), .busy(erase_busy), .done(erase_done),
    .kind(kind), .addr(erase_addr)
  );

  assign erase_kind = kind;
endmodule

// File: rtl/fe_chk.sv
`timescale 1ns/1ps
module fe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_rise,
  input logic        cs_idle,
  input logic        wel,
  input logic        busy,
  input logic [1:0]  kind,
  input logic [23:0] addr,
  input logic        sdo
);
  // R6
  launch_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  // R3
  launch_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

  // R8
  region_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr) && $stable(kind)));

  // R9
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R3
  sect_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == 2'd1) |-> (addr[11:0] == 12'h000));

  // R4
  block_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == 2'd2) |-> (addr[15:0] == 16'h0000));

  // R5
  chip_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == 2'd3) |-> (addr == 24'h000000));

  // R2
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_idle && $past(cs_idle)) |-> !sdo);
endmodule

bind flash_erase_ctrl fe_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .cs_rise(cs_rise), .cs_idle(cs_idle),
  .wel(wel), .busy(erase_busy), .kind(erase_kind), .addr(erase_addr), .sdo(sdo)
);

// File: tb/tb_flash_erase_ctrl.sv
`timescale 1ns/1ps
module tb_flash_erase_ctrl;
  localparam int SECT_C  = 400;
  localparam int BLOCK_C = 900;
  localparam int CHIP_C  = 1200;
  localparam int HALF    = 8;

  logic        clk, rst_n, cs_n, sclk, sdi;
  logic        sdo, erase_busy;
  logic [1:0]  erase_kind;
  logic [23:0] erase_addr;

  int n_chk, n_fail;
  int run_len, last_len, n_runs;
  bit finished;

  flash_erase_ctrl #(
    .SECT_CYCLES(SECT_C), .BLOCK_CYCLES(BLOCK_C), .CHIP_CYCLES(CHIP_C)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .erase_busy(erase_busy), .erase_kind(erase_kind), .erase_addr(erase_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // busy run-length monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      run_len = 0;
    end else if (erase_busy) begin
      run_len = run_len + 1;
    end else if (run_len != 0) begin
      last_len = run_len;
      n_runs   = n_runs + 1;
      run_len  = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = tx[i];
      wait_clk(HALF);
      rx[i] = sdo;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic cmd(input logic [7:0] op, input int naddr, input logic [23:0] a);
    logic [7:0] d;
    sel();
    spi_bits(op, 8, d);
    for (int k = 0; k < naddr; k++) spi_bits(a[23 - 8*k -: 8], 8, d);
    desel();
  endtask

  task automatic read_status(input string req, input logic [7:0] exp, input int reps);
    logic [7:0] d;
    sel();
    spi_bits(8'h05, 8, d);
    for (int k = 0; k < reps; k++) begin
      spi_bits(8'h00, 8, d);
      chk(req, {24'h0, d}, {24'h0, exp});
    end
    desel();
  endtask

  task automatic wait_busy_end();
    for (int k = 0; k < 4000 && erase_busy; k++) wait_clk(1);
    wait_clk(4);
  endtask

  task automatic t_reset();
    chk("R8 idle busy after reset", {31'h0, erase_busy}, 32'h0);
    chk("R8 idle kind after reset", {30'h0, erase_kind}, 32'h0);
    chk("R2 sdo deselected", {31'h0, sdo}, 32'h0);
    read_status("R2 status after reset", 8'h00, 1);
  endtask

  task automatic t_no_wel();
    int r0 = n_runs;
    cmd(8'h20, 3, 24'h01_2345);
    wait_clk(40);
    chk("R6 no busy without latch", {31'h0, erase_busy}, 32'h0);
    chk("R6 no busy run without latch", n_runs, r0);
    cmd(8'hC7, 0, 24'h0);
    wait_clk(40);
    chk("R6 chip erase without latch", {31'h0, erase_busy}, 32'h0);
  endtask

  task automatic t_framing();
    logic [7:0] d;
    int r0 = n_runs;
    sel(); spi_bits(8'h06, 5, d); desel();
    read_status("R7 partial write-enable ignored", 8'h00, 1);
    cmd(8'h06, 0, 24'h0);
    read_status("R1 latch set", 8'h02, 2);
    cmd(8'h20, 2, 24'h33_4400);
    wait_clk(40);
    chk("R7 short address no busy", {31'h0, erase_busy}, 32'h0);
    sel(); spi_bits(8'hD8, 8, d); spi_bits(8'h10, 8, d); spi_bits(8'h20, 8, d);
    spi_bits(8'h30, 8, d); spi_bits(8'h00, 3, d); desel();
    wait_clk(40);
    chk("R7 odd bit count no busy", n_runs, r0);
    read_status("R7 latch survives bad frames", 8'h02, 1);
  endtask

  task automatic t_sector();
    cmd(8'h20, 3, 24'h12_3456);
    chk("R3 sector busy", {31'h0, erase_busy}, 32'h1);
    chk("R3 sector kind", {30'h0, erase_kind}, 32'h1);
    chk("R3 sector aligned addr", {8'h0, erase_addr}, 32'h0012_3000);
    read_status("R8 status while busy", 8'h03, 1);
    wait_busy_end();
    chk("R8 sector busy length", last_len, SECT_C);
    chk("R8 kind idle after", {30'h0, erase_kind}, 32'h0);
    read_status("R9 latch cleared after sector", 8'h00, 1);
  endtask

  task automatic t_block();
    int r0;
    cmd(8'h06, 0, 24'h0);
    cmd(8'hD8, 3, 24'hAB_CDEF);
    r0 = n_runs;
    chk("R4 block kind", {30'h0, erase_kind}, 32'h2);
    chk("R4 block aligned addr", {8'h0, erase_addr}, 32'h00AB_0000);
    cmd(8'h20, 3, 24'h00_5000);
    chk("R10 addr unchanged during busy", {8'h0, erase_addr}, 32'h00AB_0000);
    chk("R10 kind unchanged during busy", {30'h0, erase_kind}, 32'h2);
    wait_busy_end();
    wait_clk(60);
    chk("R10 no second erase", n_runs, r0 + 1);
    chk("R8 block busy length", last_len, BLOCK_C);
    read_status("R9 latch cleared after block", 8'h00, 1);
  endtask

  task automatic t_chip();
    cmd(8'h06, 0, 24'h0);
    cmd(8'hC7, 0, 24'h0);
    chk("R5 chip kind", {30'h0, erase_kind}, 32'h3);
    chk("R5 chip addr", {8'h0, erase_addr}, 32'h0);
    cmd(8'h06, 0, 24'h0);
    wait_busy_end();
    chk("R8 chip busy length", last_len, CHIP_C);
    read_status("R10 write-enable ignored while busy", 8'h00, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; run_len = 0; last_len = 0; n_runs = 0; finished = 0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_no_wel();
    t_framing();
    t_sector();
    t_block();
    t_chip();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule